// File: doc/BRIEF.md
# Host-to-Local-Bus Strobe Bridge

The bridge takes single memory read and write requests from a simple host request/acknowledge interface and turns each one into a strobed access on an external 16-bit peripheral port. The port has eight chip selects, separate read and write strobes, a 16-bit address output and split data in/out buses with an output enable. All strobe timing is counted in whole periods of the bridge clock, and no host bus clock is involved.

A small control register sets the active level of every chip select and of the read and write strobes. It also chooses whether a host reset input is forwarded to a general-purpose output as is or inverted. Register accesses and memory accesses share the same request interface and are told apart by a command code. Host byte enables are accepted but play no part in any access.

The sequencer has five states:
- `ST_IDLE`: waits for a request.
- `ST_SETUP`: one cycle with the address and chip select, plus write data on writes.
- `ST_STROBE`: the read or write strobe is held for `STROBE_CYCLES` cycles.
- `ST_HOLD`: one cycle with the strobe released and the chip select still held.
- `ST_ACK`: a one-cycle acknowledge with the chip select released.

The transitions are:
- IDLE to SETUP on a memory request.
- IDLE to ACK on a register or unsupported request.
- SETUP to STROBE after one cycle.
- STROBE to HOLD when the strobe counter reaches its last value.
- HOLD to ACK after one cycle.
- ACK to IDLE after one cycle.

Top module: `lbus_strobe_bridge`

## Requirements
- R1: After reset the control register is zero, so every chip select, `lb_rd` and `lb_wr` sit low (inactive, active-high), `lb_oe` and `host_ack` are 0, and `gp_rst_out` equals `hrst_in`.
- R2: A request with `host_cmd`=2'b01 is a register access. It is acknowledged in the cycle after it is accepted. When `host_we`=1, `host_wdata[15:0]` is written. The register holds chip-select polarity in bits 7:0 (bit n for chip select n), write-strobe polarity in bit 8, read-strobe polarity in bit 9 and reset inversion in bit 10. Bits 15:11 read as zero. `host_rdata` returns the register contents after the access, zero-extended.
- R3: Chip select n is driven at level 1 when active and its polarity bit is 0, and at level 0 when active and its polarity bit is 1. While the chip select is inactive it rests at the opposite level.
- R4: The read and write strobes follow the same polarity rule, using bits 9 and 8 respectively.
- R5: `gp_rst_out` equals `hrst_in` when bit 10 is 0 and its inverse when bit 10 is 1, in the same cycle.
- R6: A memory request (`host_cmd`=2'b10) asserts exactly one chip select, chosen by `host_addr[18:16]`. `lb_addr` carries `host_addr[15:2]` with bits 1:0 forced to 00.
- R7: A memory access runs as follows: one setup cycle with the chip select active, then `STROBE_CYCLES` (default 2) cycles of read or write strobe, then one hold cycle with the chip select still active, then one cycle with the chip select released and `host_ack`=1.
- R8: On a memory write, `lb_dout` carries `host_wdata[15:0]` and `lb_oe` is 1 for exactly the setup, strobe and hold cycles. `lb_oe` is 0 at all other times.
- R9: On a memory read, `lb_din` is captured at the clock edge that ends the last strobe cycle and is returned on `host_rdata` zero-extended. A memory write returns 0.
- R10: `host_be` has no effect on any access.
- R11: Commands 2'b00 and 2'b11 are acknowledged one cycle after acceptance with `host_rdata`=0 and no chip select or strobe activity.
- R12: A register write changes the idle output levels starting from the acknowledge cycle. The register never changes while a chip select is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock; all strobe timing counts its periods |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request; held until `host_ack` |
| host_cmd | input | 2 | 2'b10 memory, 2'b01 register, others unsupported |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | [18:16] chip select index, [15:0] local address |
| host_wdata | input | 32 | Write data; low 16 bits used |
| host_be | input | 4 | Byte enables; ignored |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read data, valid with `host_ack` |
| lb_addr | output | 16 | Local address, bits 1:0 always 0 |
| lb_cs | output | 8 | Chip selects, polarity per register bits 7:0 |
| lb_rd | output | 1 | Read strobe |
| lb_wr | output | 1 | Write strobe |
| lb_dout | output | 16 | Local write data |
| lb_oe | output | 1 | Output enable for `lb_dout` |
| lb_din | input | 16 | Local read data |
| hrst_in | input | 1 | Host reset level to forward |
| gp_rst_out | output | 1 | Forwarded reset, optionally inverted |

## Verification
The assertions assume that the host keeps `host_req` and its fields steady until it sees `host_ack`, and drops the request in that same cycle. They also assume that `lb_din` is stable around the capturing edge. The stimulus drives every input half a period away from the active edge and releases the request on the acknowledge cycle, so no request is ever presented to a busy sequencer. The bench drives `lb_din` with a value that changes every cycle, so a capture on the wrong edge would show up as a data mismatch.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int REG_W       = 16;
    localparam int CTRL_BASE   = 8;
    localparam int WR_POL_BIT  = 0;
    localparam int RD_POL_BIT  = 1;
    localparam int RST_INV_BIT = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_ACK
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_OTHER = 2'b00,
        CMD_REG   = 2'b01,
        CMD_MEM   = 2'b10,
        CMD_RSVD  = 2'b11
    } host_cmd_t;

endpackage

// File: rtl/lbs_ctrl_regs.sv
module lbs_ctrl_regs
    import lbs_pkg::*;
#(
    parameter int NUM_CS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [NUM_CS-1:0] cs_pol,
    output logic              wr_pol,
    output logic              rd_pol,
    output logic              rst_inv,
    output logic [REG_W-1:0]  rd_value
);

    localparam int RESV_LO = CTRL_BASE + RST_INV_BIT + 1;

    logic unused_resv;
    assign unused_resv = ^wr_data[REG_W-1:RESV_LO];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_pol  <= '0;
            wr_pol  <= 1'b0;
            rd_pol  <= 1'b0;
            rst_inv <= 1'b0;
        end else if (wr_en) begin
            cs_pol  <= wr_data[NUM_CS-1:0];
            wr_pol  <= wr_data[CTRL_BASE+WR_POL_BIT];
            rd_pol  <= wr_data[CTRL_BASE+RD_POL_BIT];
            rst_inv <= wr_data[CTRL_BASE+RST_INV_BIT];
        end
    end

    always_comb begin
        rd_value                         = '0;
        rd_value[NUM_CS-1:0]             = cs_pol;
        rd_value[CTRL_BASE+WR_POL_BIT]   = wr_pol;
        rd_value[CTRL_BASE+RD_POL_BIT]   = rd_pol;
        rd_value[CTRL_BASE+RST_INV_BIT]  = rst_inv;
    end

endmodule

// File: rtl/lbs_seq.sv
module lbs_seq
    import lbs_pkg::*;
#(
    parameter int LADDR_W       = 16,
    parameter int DATA_W        = 16,
    parameter int NUM_CS        = 8,
    parameter int STROBE_CYCLES = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  host_req,
    input  logic [1:0]                            host_cmd,
    input  logic                                  host_we,
    input  logic [LADDR_W+$clog2(NUM_CS)-1:0]     host_addr,
    input  logic [DATA_W-1:0]                     host_wdata,
    input  logic [DATA_W-1:0]                     lb_din,
    output logic                                  reg_wr_en,
    output logic [NUM_CS-1:0]                     cs_act,
    output logic                                  rd_act,
    output logic                                  wr_act,
    output logic [LADDR_W-1:0]                    lb_addr,
    output logic [DATA_W-1:0]                     lb_dout,
    output logic                                  lb_oe,
    output logic                                  ack,
    output logic                                  sel_reg,
    output logic [DATA_W-1:0]                     rdata
);

    localparam int CSSEL_W = $clog2(NUM_CS);
    localparam int HADDR_W = LADDR_W + CSSEL_W;
    localparam int CNT_W   = (STROBE_CYCLES > 1) ? $clog2(STROBE_CYCLES) : 1;
    localparam int LEN_W   = $clog2(STROBE_CYCLES + 2);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(STROBE_CYCLES - 1);
    localparam logic [LEN_W-1:0] LEN_EXP  = LEN_W'(STROBE_CYCLES);

    seq_state_t           state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [CSSEL_W-1:0]   cs_idx_q;
    logic [LADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic [DATA_W-1:0]    rdata_q;
    logic                 we_q;
    logic                 sel_reg_q;
    logic                 accept;
    logic                 in_access;
    logic                 strobe_on;
    logic                 unused_lsb;

    assign unused_lsb = ^host_addr[1:0];
    assign accept     = (state_q == ST_IDLE) && host_req;
    assign reg_wr_en  = accept && (host_cmd == CMD_REG) && host_we;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (host_req) begin
                    if (host_cmd == CMD_MEM) state_d = ST_SETUP;
                    else                     state_d = ST_ACK;
                end
            end
            ST_SETUP:  state_d = ST_STROBE;
            ST_STROBE: if (cnt_q == LAST_CNT) state_d = ST_HOLD;
            ST_HOLD:   state_d = ST_ACK;
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        in_access = 1'b0;
        strobe_on = 1'b0;
        ack       = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SETUP:  in_access = 1'b1;
            ST_STROBE: begin
                in_access = 1'b1;
                strobe_on = 1'b1;
            end
            ST_HOLD:   in_access = 1'b1;
            ST_ACK:    ack = 1'b1;
            default:   ;
        endcase
    end

    // Strobe width counter and access fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            cs_idx_q  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rdata_q   <= '0;
            we_q      <= 1'b0;
            sel_reg_q <= 1'b0;
        end else begin
            if (state_q == ST_STROBE) cnt_q <= cnt_q + 1'b1;
            else                      cnt_q <= '0;
            if (accept) begin
                sel_reg_q <= (host_cmd == CMD_REG);
                rdata_q   <= '0;
                if (host_cmd == CMD_MEM) begin
                    cs_idx_q <= host_addr[HADDR_W-1:LADDR_W];
                    addr_q   <= {host_addr[LADDR_W-1:2], 2'b00};
                    wdata_q  <= host_wdata;
                    we_q     <= host_we;
                end
            end else if ((state_q == ST_STROBE) && (cnt_q == LAST_CNT) && !we_q) begin
                rdata_q <= lb_din;
            end
        end
    end

    // One-hot chip-select decode
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs_dec
        assign cs_act[gi] = in_access && (cs_idx_q == CSSEL_W'(gi));
    end

    assign rd_act  = strobe_on && !we_q;
    assign wr_act  = strobe_on && we_q;
    assign lb_oe   = in_access && we_q;
    assign lb_addr = addr_q;
    assign lb_dout = wdata_q;
    assign sel_reg = sel_reg_q;
    assign rdata   = rdata_q;

    // Run length of the current strobe, used only for checking
    logic [LEN_W-1:0] chk_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                chk_len_q <= '0;
        else if (rd_act || wr_act) chk_len_q <= chk_len_q + 1'b1;
        else                       chk_len_q <= '0;
    end

    // R6
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_act));

    // R7
    strobe_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act || wr_act) |-> (cs_act != '0));

    // R7
    strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_act || wr_act) |-> (chk_len_q == LEN_EXP));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7
    ack_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (cs_act == '0));

    // R8
    oe_not_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_oe |-> !rd_act);

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_act && wr_act));

endmodule

// File: rtl/lbs_pol_drive.sv
module lbs_pol_drive #(
    parameter int NUM_CS = 8
) (
    input  logic [NUM_CS-1:0] cs_act,
    input  logic [NUM_CS-1:0] cs_pol,
    input  logic              rd_act,
    input  logic              rd_pol,
    input  logic              wr_act,
    input  logic              wr_pol,
    input  logic              hrst_in,
    input  logic              rst_inv,
    output logic [NUM_CS-1:0] lb_cs,
    output logic              lb_rd,
    output logic              lb_wr,
    output logic              gp_rst_out
);

    // Active level is 1 when the polarity bit is 0, and 0 when it is 1
    for (genvar gi = 0; gi < NUM_CS; gi++) begin : g_cs_pol
        assign lb_cs[gi] = cs_act[gi] ^ cs_pol[gi];
    end

    assign lb_rd      = rd_act ^ rd_pol;
    assign lb_wr      = wr_act ^ wr_pol;
    assign gp_rst_out = hrst_in ^ rst_inv;

endmodule

// File: rtl/lbus_strobe_bridge.sv
module lbus_strobe_bridge
    import lbs_pkg::*;
#(
    parameter int LADDR_W       = 16,
    parameter int DATA_W        = 16,
    parameter int HDATA_W       = 32,
    parameter int NUM_CS        = 8,
    parameter int STROBE_CYCLES = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                host_req,
    input  logic [1:0]                          host_cmd,
    input  logic                                host_we,
    input  logic [LADDR_W+$clog2(NUM_CS)-1:0]   host_addr,
    input  logic [HDATA_W-1:0]                  host_wdata,
    input  logic [HDATA_W/8-1:0]                host_be,
    output logic                                host_ack,
    output logic [HDATA_W-1:0]                  host_rdata,
    output logic [LADDR_W-1:0]                  lb_addr,
    output logic [NUM_CS-1:0]                   lb_cs,
    output logic                                lb_rd,
    output logic                                lb_wr,
    output logic [DATA_W-1:0]                   lb_dout,
    output logic                                lb_oe,
    input  logic [DATA_W-1:0]                   lb_din,
    input  logic                                hrst_in,
    output logic                                gp_rst_out
);

    logic                 reg_wr_en;
    logic [NUM_CS-1:0]    cs_pol;
    logic                 wr_pol, rd_pol, rst_inv;
    logic [REG_W-1:0]     reg_value;
    logic [NUM_CS-1:0]    cs_act;
    logic                 rd_act, wr_act;
    logic                 sel_reg;
    logic [DATA_W-1:0]    seq_rdata;
    logic                 unused_host;

    assign unused_host = ^{host_be, host_wdata[HDATA_W-1:DATA_W]};

    lbs_ctrl_regs #(.NUM_CS(NUM_CS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .wr_data  (host_wdata[REG_W-1:0]),
        .cs_pol   (cs_pol),
        .wr_pol   (wr_pol),
        .rd_pol   (rd_pol),
        .rst_inv  (rst_inv),
        .rd_value (reg_value)
    );

    lbs_seq #(
        .LADDR_W       (LADDR_W),
        .DATA_W        (DATA_W),
        .NUM_CS        (NUM_CS),
        .STROBE_CYCLES (STROBE_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_cmd   (host_cmd),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata[DATA_W-1:0]),
        .lb_din     (lb_din),
        .reg_wr_en  (reg_wr_en),
        .cs_act     (cs_act),
        .rd_act     (rd_act),
        .wr_act     (wr_act),
        .lb_addr    (lb_addr),
        .lb_dout    (lb_dout),
        .lb_oe      (lb_oe),
        .ack        (host_ack),
        .sel_reg    (sel_reg),
        .rdata      (seq_rdata)
    );

    lbs_pol_drive #(.NUM_CS(NUM_CS)) u_pol (
        .cs_act     (cs_act),
        .cs_pol     (cs_pol),
        .rd_act     (rd_act),
        .rd_pol     (rd_pol),
        .wr_act     (wr_act),
        .wr_pol     (wr_pol),
        .hrst_in    (hrst_in),
        .rst_inv    (rst_inv),
        .lb_cs      (lb_cs),
        .lb_rd      (lb_rd),
        .lb_wr      (lb_wr),
        .gp_rst_out (gp_rst_out)
    );

    assign host_rdata = HDATA_W'(sel_reg ? reg_value : seq_rdata);

    // R6
    addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lb_addr[1:0] == 2'b00);

    // R12
    pol_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act != '0) |=> $stable(reg_value));

    // R9
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |-> (host_rdata[HDATA_W-1:DATA_W] == '0));

endmodule

// File: tb/lbus_strobe_bridge_bench.sv
module lbus_strobe_bridge_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSTB       = 2;
    localparam int ACKP       = NSTB + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [1:0]  host_cmd = 2'b00;
    logic        host_we = 1'b0;
    logic [18:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  host_be = '0;
    logic        host_ack;
    logic [31:0] host_rdata;
    logic [15:0] lb_addr;
    logic [7:0]  lb_cs;
    logic        lb_rd, lb_wr;
    logic [15:0] lb_dout;
    logic        lb_oe;
    logic [15:0] lb_din = 16'h0055;
    logic        hrst_in = 1'b0;
    logic        gp_rst_out;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lbus_strobe_bridge u_lbus_strobe_bridge (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_cmd(host_cmd),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_be(host_be), .host_ack(host_ack), .host_rdata(host_rdata),
        .lb_addr(lb_addr), .lb_cs(lb_cs), .lb_rd(lb_rd), .lb_wr(lb_wr),
        .lb_dout(lb_dout), .lb_oe(lb_oe), .lb_din(lb_din),
        .hrst_in(hrst_in), .gp_rst_out(gp_rst_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference model: phase -1 idle, 0 setup, 1..NSTB strobe,
    // NSTB+1 hold, ACKP acknowledge
    int          m_phase = -1;
    logic        m_we = 1'b0, m_isreg = 1'b0;
    int          m_cs = 0;
    logic [15:0] m_addr = '0, m_wdata = '0, m_rdata = '0, m_pol = '0;
    logic [15:0] obs_wdata = '0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = -1; m_pol = '0; m_rdata = '0; m_isreg = 1'b0; m_we = 1'b0;
        end else if (m_phase == -1) begin
            if (host_req) begin
                if (host_cmd == 2'b10) begin
                    m_phase = 0; m_we = host_we; m_cs = int'(host_addr[18:16]);
                    m_addr = host_addr[15:0] & 16'hFFFC; m_wdata = host_wdata[15:0];
                    m_rdata = '0; m_isreg = 1'b0;
                end else if (host_cmd == 2'b01) begin
                    if (host_we) m_pol = host_wdata[15:0] & 16'h07FF;
                    m_isreg = 1'b1; m_phase = ACKP;
                end else begin
                    m_rdata = '0; m_isreg = 1'b0; m_phase = ACKP;
                end
            end
        end else begin
            if (m_phase == NSTB && !m_we) m_rdata = lb_din;
            if (m_phase == ACKP) m_phase = -1;
            else m_phase++;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        logic [7:0]  e_cs;
        logic        in_acc, e_rd, e_wr, e_oe;
        string       t;
        in_acc = (m_phase >= 0) && (m_phase <= NSTB + 1);
        for (int i = 0; i < 8; i++) e_cs[i] = (in_acc && (m_cs == i)) ^ m_pol[i];
        e_rd = (m_phase >= 1 && m_phase <= NSTB && !m_we) ^ m_pol[9];
        e_wr = (m_phase >= 1 && m_phase <= NSTB && m_we) ^ m_pol[8];
        e_oe = in_acc && m_we;
        t = rst_n ? "R3 lb_cs" : "R1 lb_cs";
        check(t, 32'(lb_cs), 32'(e_cs));
        check(rst_n ? "R4 lb_rd" : "R1 lb_rd", 32'(lb_rd), 32'(e_rd));
        check(rst_n ? "R4 lb_wr" : "R1 lb_wr", 32'(lb_wr), 32'(e_wr));
        check(rst_n ? "R8 lb_oe" : "R1 lb_oe", 32'(lb_oe), 32'(e_oe));
        check(rst_n ? "R7 host_ack" : "R1 host_ack", 32'(host_ack), 32'(m_phase == ACKP));
        check(rst_n ? "R5 gp_rst_out" : "R1 gp_rst_out", 32'(gp_rst_out), 32'(hrst_in ^ m_pol[10]));
        if (in_acc) check("R6 lb_addr", 32'(lb_addr), 32'(m_addr));
        if (e_oe) check("R8 lb_dout", 32'(lb_dout), 32'(m_wdata));
        if (m_phase == ACKP)
            check("R9 host_rdata", host_rdata, 32'(m_isreg ? m_pol : m_rdata));
        if (m_phase >= 1 && m_phase <= NSTB && m_we) obs_wdata = lb_dout;
        cyc++;
        lb_din = 16'(cyc * 16'h03B1 + 16'h0055);
        if (cyc > 20000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic access(input logic [1:0] cmd, input logic we, input logic [18:0] addr,
                          input logic [31:0] wd, input logic [3:0] be, output logic [31:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_cmd = cmd; host_we = we;
        host_addr = addr; host_wdata = wd; host_be = be;
        rd = '0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (host_ack) begin
                rd = host_rdata;
                break;
            end
        end
        host_req = 1'b0; host_be = ~be;
    endtask

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        hrst_in = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;

        // R10: byte enables all low, data still written
        access(2'b10, 1'b1, 19'h3_1236, 32'hDEAD_BEEF, 4'h0, rd);
        check("R10 write data with no byte enables", 32'(obs_wdata), 32'h0000_BEEF);
        check("R9 write returns zero", rd, 32'h0);
        access(2'b10, 1'b0, 19'h5_ABCD, 32'h0, 4'hF, rd);
        check("R9 read upper half zero", 32'(rd[31:16]), 32'h0);
        check("R9 read captured value", rd, 32'(m_rdata));
        access(2'b10, 1'b0, 19'h5_ABCD, 32'h0, 4'h3, rd);
        check("R10 read with partial byte enables", rd, 32'(m_rdata));

        // R11
        access(2'b00, 1'b1, 19'h1_0000, 32'hFFFF_FFFF, 4'hF, rd);
        check("R11 unsupported command data", rd, 32'h0);
        access(2'b11, 1'b0, 19'h2_0004, 32'h1111_2222, 4'hF, rd);
        check("R11 reserved command data", rd, 32'h0);

        // R2 and R12: polarity register
        access(2'b01, 1'b1, 19'h0, 32'h1234_FFA5, 4'h0, rd);
        check("R2 write readback", rd, 32'h0000_07A5);
        @(negedge clk);
        check("R12 idle cs level after write", 32'(lb_cs), 32'h0000_00A5);
        check("R4 idle rd level inverted", 32'(lb_rd), 32'h1);
        access(2'b01, 1'b0, 19'h0, 32'h0, 4'hF, rd);
        check("R2 read", rd, 32'h0000_07A5);

        hrst_in = 1'b0; @(negedge clk);
        check("R5 inverted forward", 32'(gp_rst_out), 32'h1);
        access(2'b10, 1'b1, 19'h0_00F3, 32'h0000_1357, 4'h1, rd);
        access(2'b10, 1'b0, 19'h7_FFFF, 32'h0, 4'h0, rd);
        check("R9 read with inverted strobes", rd, 32'(m_rdata));
        access(2'b10, 1'b1, 19'h7_8002, 32'hCAFE_2468, 4'hC, rd);

        access(2'b01, 1'b1, 19'h0, 32'h0000_0100, 4'hF, rd);
        check("R2 single bit write", rd, 32'h0000_0100);
        hrst_in = 1'b1;
        access(2'b10, 1'b0, 19'h2_4444, 32'h0, 4'hF, rd);
        access(2'b10, 1'b1, 19'h6_0009, 32'h0000_9ABC, 4'hF, rd);
        check("R8 write data", 32'(obs_wdata), 32'h0000_9ABC);
        for (int c = 0; c < 8; c++)
            access(2'b10, c[0], {c[2:0], 16'h1001}, 32'(c * 32'h111), 4'h0, rd);

        access(2'b01, 1'b1, 19'h0, 32'h0, 4'hF, rd);
        check("R2 cleared", rd, 32'h0);
        repeat (3) @(negedge clk);
        check("R3 idle cs low", 32'(lb_cs), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule